// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Multiprocessor Address Filter

This block receives asynchronous serial frames of eleven bit periods: a start bit, eight data bits sent least significant first, a ninth bit, and a stop bit. The line is oversampled sixteen times per bit. The sample tick comes from a programmable divider. A frame that ends with a valid stop bit is offered to an address filter. The filter decides whether the receive flag is raised and whether the received byte and ninth bit are shown on the outputs.

When filtering is enabled, a frame whose ninth bit is 1 is treated as an address. The frame is accepted when its byte matches either of two addresses built from the slave address and mask registers. The first is a masked individual address, where a mask bit of zero makes that position a don't-care. The second is a broadcast address, where each 1 in (address OR mask) demands a 1 in the received byte. A single address byte can therefore select any chosen group of slaves. Frames whose ninth bit is 0 are dropped while filtering is on, so a slave hears data only after software has turned filtering off. Software clears the flag through a strobe.

Receiver states:

- `RX_IDLE` waits for a low sample on a tick (transition to `RX_START`).
- `RX_START` checks the line at mid-bit. It returns to `RX_IDLE` if the line is high, and goes to `RX_BITS` after sixteen ticks.
- `RX_BITS` votes nine bits and goes to `RX_STOP` after the last one.
- `RX_STOP` votes the stop bit and goes to `RX_DONE` on the tick after its third sample.
- `RX_DONE` lasts one clock, presents the frame to the filter, and returns to `RX_IDLE`.

Top module: `mp_addr_rx`

## Requirements
- R1: After reset, `rx_flag`, `rx_byte` and `rx_bit9` are 0, and the slave address, mask and filter-enable registers are 0.
- R2: A tick occurs every `baud_div`+1 clocks and a bit lasts 16 ticks. A frame is one start bit (0), eight data bits with the least significant bit first, a ninth bit, and a stop bit. An accepted frame shows its data on `rx_byte` and its ninth bit on `rx_bit9`.
- R3: A falling edge starts a frame only if the line is still low at the mid-bit sample of the start bit. A low pulse shorter than half a bit produces no frame.
- R4: Each data bit, the ninth bit and the stop bit take the majority of three samples at ticks 6, 7 and 8 of the bit. One corrupted sample does not change the bit.
- R5: A frame whose stop bit reads 0 is discarded. It does not set `rx_flag` and leaves `rx_byte` and `rx_bit9` unchanged.
- R6: With filtering disabled, every frame with a valid stop bit is accepted, whatever its ninth bit and the address registers hold.
- R7: With filtering enabled, a frame whose ninth bit is 0 is not accepted.
- R8: With filtering enabled and a ninth bit of 1, the byte is accepted when ((byte XOR address) AND mask) is 0.
- R9: With filtering enabled and a ninth bit of 1, the byte is accepted when (byte AND (address OR mask)) equals (address OR mask).
- R10: With address and mask both 0, every address frame is accepted while filtering is enabled.
- R11: `rx_flag` stays set until a `flag_clr` pulse clears it. If an acceptance arrives in the same clock as `flag_clr`, the flag is set.
- R12: `addr_we` loads `wr_data` into the slave address, `mask_we` loads `wr_data` into the mask, and `filt_we` loads `wr_data[0]` into the filter enable.
- R13: A frame that is not accepted leaves `rx_byte` and `rx_bit9` unchanged, and a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Tick period minus one, in clocks |
| rx | input | 1 | Serial line, idle high |
| addr_we | input | 1 | Load the slave address from `wr_data` |
| mask_we | input | 1 | Load the address mask from `wr_data` |
| filt_we | input | 1 | Load the filter enable from `wr_data[0]` |
| wr_data | input | DATA_W | Write data for the configuration registers |
| flag_clr | input | 1 | Clear the receive flag |
| rx_byte | output | DATA_W | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_flag | output | 1 | Receive flag |

## Verification
The flag and the captured byte change one clock after `RX_DONE` begins. `RX_DONE` follows the tick after the third stop-bit sample, which falls about 10.6 bit periods after the start edge. To respect that timing, the bench holds the line idle for a further full bit period after each frame before it samples the outputs. Sampling happens on the falling clock edge, and the next frame or configuration write is never started before that sample. Configuration writes take effect on the next clock and are always made well before a frame's start bit. A rejected frame is judged by comparing the outputs with the values the bench recorded for the last accepted frame.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_DONE
    } rx_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mprx_baud.sv
module mprx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/mprx_frame.sv
module mprx_frame
    import mprx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int NBITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_in,
    output logic             done,
    output logic             stop_ok,
    output logic [NBITS-1:0] word
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(NBITS + 1);
    localparam logic [CW-1:0] MID   = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] S_LO  = CW'(OVS / 2 - 2);
    localparam logic [CW-1:0] S_HI  = CW'(OVS / 2);
    localparam logic [CW-1:0] S_END = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] LAST  = CW'(OVS - 1);
    localparam logic [BW-1:0] BLAST = BW'(NBITS - 1);

    rx_state_t     state_q, state_d;
    logic [1:0]    sync_q;
    logic          rx_s;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bitn_q;
    logic [2:0]    samp_q;
    logic          vote;

    assign rx_s = sync_q[1];
    assign vote = maj3(samp_q[0], samp_q[1], samp_q[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_in};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !rx_s) state_d = RX_START;
            RX_START: if (tick) begin
                          if (cnt_q == MID && rx_s) state_d = RX_IDLE;
                          else if (cnt_q == LAST)   state_d = RX_BITS;
                      end
            RX_BITS:  if (tick && cnt_q == LAST && bitn_q == BLAST) state_d = RX_STOP;
            RX_STOP:  if (tick && cnt_q == S_END) state_d = RX_DONE;
            RX_DONE:  state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // counters, samples and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bitn_q  <= '0;
            samp_q  <= '0;
            word    <= '0;
            stop_ok <= 1'b0;
        end else begin
            if (state_q != state_d) begin
                cnt_q <= '0;
            end else if (tick && state_q != RX_IDLE) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            if (state_q == RX_IDLE) bitn_q <= '0;
            if (tick && (state_q == RX_BITS || state_q == RX_STOP)) begin
                if (cnt_q == S_LO) samp_q[0] <= rx_s;
                if (cnt_q == MID)  samp_q[1] <= rx_s;
                if (cnt_q == S_HI) samp_q[2] <= rx_s;
            end
            if (tick && state_q == RX_BITS && cnt_q == LAST) begin
                word   <= {vote, word[NBITS-1:1]};
                bitn_q <= bitn_q + 1'b1;
            end
            if (tick && state_q == RX_STOP && cnt_q == S_END) begin
                stop_ok <= vote;
            end
        end
    end

    // outputs
    always_comb begin
        done = (state_q == RX_DONE);
    end
endmodule

// File: rtl/mprx_match.sv
module mprx_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] slave_addr,
    input  logic [W-1:0] addr_mask,
    input  logic [W-1:0] rx_addr,
    output logic         hit_given,
    output logic         hit_bcast
);
    logic [W-1:0] bcast;
    logic [W-1:0] diff;

    assign bcast = slave_addr | addr_mask;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            assign diff[g] = (rx_addr[g] ^ slave_addr[g]) & addr_mask[g];
        end
    endgenerate

    assign hit_given = (diff == '0);
    assign hit_bcast = ((rx_addr & bcast) == bcast);
endmodule

// File: rtl/mp_addr_rx.sv
module mp_addr_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              rx,
    input  logic              addr_we,
    input  logic              mask_we,
    input  logic              filt_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_flag
);
    localparam int NBITS = DATA_W + 1;

    logic              tick;
    logic              frm_done;
    logic              frm_ok;
    logic [NBITS-1:0]  frm_word;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;
    logic              filt_en_q;
    logic              hit_given;
    logic              hit_bcast;
    logic              accept;

    mprx_baud #(.DIV_W(DIV_W)) i_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (tick)
    );

    mprx_frame #(.OVS(OVS), .NBITS(NBITS)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .rx_in  (rx),
        .done   (frm_done),
        .stop_ok(frm_ok),
        .word   (frm_word)
    );

    mprx_match #(.W(DATA_W)) i_match (
        .slave_addr(addr_q),
        .addr_mask (mask_q),
        .rx_addr   (frm_word[DATA_W-1:0]),
        .hit_given (hit_given),
        .hit_bcast (hit_bcast)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            mask_q    <= '0;
            filt_en_q <= 1'b0;
        end else begin
            if (addr_we) addr_q    <= wr_data;
            if (mask_we) mask_q    <= wr_data;
            if (filt_we) filt_en_q <= wr_data[0];
        end
    end

    always_comb begin
        accept = frm_done && frm_ok &&
                 (!filt_en_q || (frm_word[DATA_W] && (hit_given || hit_bcast)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_bit9 <= 1'b0;
            rx_flag <= 1'b0;
        end else if (accept) begin
            rx_byte <= frm_word[DATA_W-1:0];
            rx_bit9 <= frm_word[DATA_W];
            rx_flag <= 1'b1;
        end else if (flag_clr) begin
            rx_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/mprx_checks.sv
module mprx_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frm_done,
    input logic         frm_ok,
    input logic         frm_bit9,
    input logic         filt_en,
    input logic         flag_clr,
    input logic         rx_flag,
    input logic [W-1:0] rx_byte
);
    p_flag_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(frm_done && frm_ok));

    p_bad_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_ok && !rx_flag) |=> !rx_flag);

    p_data_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && filt_en && !frm_bit9 && !rx_flag) |=> !rx_flag);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !frm_done) |=> !rx_flag);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !flag_clr) |=> rx_flag);

    p_byte_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> $stable(rx_byte));
endmodule

bind mp_addr_rx mprx_checks #(.W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frm_done(frm_done),
    .frm_ok  (frm_ok),
    .frm_bit9(frm_word[DATA_W]),
    .filt_en (filt_en_q),
    .flag_clr(flag_clr),
    .rx_flag (rx_flag),
    .rx_byte (rx_byte)
);

// File: tb/test_mp_addr_rx.sv
module test_mp_addr_rx;
    localparam int BIT = 64;   // baud_div 3 -> 4 clocks per tick, 16 ticks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic        rx = 1'b1;
    logic        addr_we = 1'b0, mask_we = 1'b0, filt_we = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_bit9;
    logic        rx_flag;

    int   n_chk = 0;
    int   n_bad = 0;
    logic fin = 1'b0;
    logic [7:0] exp_byte = '0;
    logic       exp_b9 = 1'b0;

    always #10 clk = ~clk;

    mp_addr_rx i_mp_addr_rx (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx(rx),
        .addr_we(addr_we), .mask_we(mask_we), .filt_we(filt_we),
        .wr_data(wr_data), .flag_clr(flag_clr),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_flag(rx_flag)
    );

    // {filt, addr, mask, bit9, data, stop, accept}
    localparam logic [27:0] VEC [12] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 8'hA5, 1'b1, 1'b1},
        {1'b0, 8'hC0, 8'hFD, 1'b0, 8'h3C, 1'b1, 1'b1},
        {1'b1, 8'hC0, 8'hFD, 1'b1, 8'hC2, 1'b1, 1'b1},
        {1'b1, 8'hC0, 8'hFE, 1'b1, 8'hC2, 1'b1, 1'b0},
        {1'b1, 8'hC0, 8'hFE, 1'b1, 8'hC0, 1'b1, 1'b1},
        {1'b1, 8'hC0, 8'hFD, 1'b1, 8'hC0, 1'b1, 1'b1},
        {1'b1, 8'hC0, 8'hFD, 1'b0, 8'hC2, 1'b1, 1'b0},
        {1'b1, 8'hC0, 8'hF9, 1'b1, 8'hFF, 1'b1, 1'b1},
        {1'b1, 8'hC0, 8'hF9, 1'b1, 8'hF8, 1'b1, 1'b0},
        {1'b1, 8'h00, 8'h00, 1'b1, 8'h5A, 1'b1, 1'b1},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0},
        {1'b1, 8'hC0, 8'hFD, 1'b1, 8'hC2, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        {addr_we, mask_we, filt_we} = sel;
        wr_data = d;
        @(negedge clk);
        {addr_we, mask_we, filt_we} = 3'b000;
    endtask

    task automatic clr;
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // glitch_bit >= 0 inverts 3 clocks at the centre of that data bit
    task automatic send(input logic [7:0] d, input logic b9, input logic stp,
                        input int glitch_bit);
        logic [10:0] f;
        f = {stp, b9, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            rx = f[i];
            if (i == glitch_bit + 1) begin
                repeat (BIT/2 - 1) @(negedge clk);
                rx = ~f[i];
                repeat (3) @(negedge clk);
                rx = f[i];
                repeat (BIT/2 - 4) @(negedge clk);
            end else begin
                repeat (BIT - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        rx = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    function automatic string vtag(input logic [27:0] v);
        if (!v[1])           return "R5 R12";
        if (!v[27])          return "R6 R2 R12";
        if (!v[10])          return "R7 R12";
        if (v[26:11] == '0)  return "R10 R12";
        if (v[0] && ((v[9:2] ^ v[26:19]) & v[18:11]) != 0) return "R9 R12";
        return "R8 R12";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 flag", {8'h0, rx_flag}, 9'h0);
        chk("R1 byte", {rx_bit9, rx_byte}, 9'h0);

        // R10/R1: reset address and mask accept any address with filter on
        wr(3'b001, 8'h01);
        send(8'h37, 1'b1, 1'b1, -1);
        chk("R10 flag", {8'h0, rx_flag}, 9'h1);
        chk("R10 byte", {rx_bit9, rx_byte}, {1'b1, 8'h37});
        exp_byte = 8'h37; exp_b9 = 1'b1;

        foreach (VEC[k]) begin
            logic [27:0] v;
            v = VEC[k];
            wr(3'b100, v[26:19]);
            wr(3'b010, v[18:11]);
            wr(3'b001, {7'b0, v[27]});
            clr();
            send(v[9:2], v[10], v[1], -1);
            chk(vtag(v), {8'h0, rx_flag}, {8'h0, v[0]});
            if (v[0]) begin
                exp_byte = v[9:2]; exp_b9 = v[10];
            end
            chk({vtag(v), " R13 byte"}, {rx_bit9, rx_byte}, {exp_b9, exp_byte});
        end

        // R3: short low pulse is not a start bit
        wr(3'b001, 8'h00);
        clr();
        @(negedge clk); rx = 1'b0;
        repeat (20) @(negedge clk); rx = 1'b1;
        repeat (3*BIT) @(negedge clk);
        chk("R3 glitch flag", {8'h0, rx_flag}, 9'h0);
        chk("R3 glitch byte", {rx_bit9, rx_byte}, {exp_b9, exp_byte});
        send(8'h96, 1'b0, 1'b1, -1);
        chk("R3 after glitch", {rx_bit9, rx_byte}, {1'b0, 8'h96});

        // R4: one corrupted sample is outvoted
        clr();
        send(8'h00, 1'b0, 1'b1, 3);
        chk("R4 low bit", {rx_bit9, rx_byte}, 9'h000);
        clr();
        send(8'hFF, 1'b1, 1'b1, 5);
        chk("R4 high bit", {rx_bit9, rx_byte}, 9'h1FF);
        exp_byte = 8'hFF; exp_b9 = 1'b1;

        // R11/R13: flag held across a rejected frame, then cleared
        wr(3'b100, 8'hC0);
        wr(3'b010, 8'hFE);
        wr(3'b001, 8'h01);
        send(8'hC2, 1'b1, 1'b1, -1);
        chk("R11 held", {8'h0, rx_flag}, 9'h1);
        chk("R13 unchanged", {rx_bit9, rx_byte}, {exp_b9, exp_byte});
        clr();
        @(negedge clk);
        chk("R11 cleared", {8'h0, rx_flag}, 9'h0);

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule